// File: doc/BRIEF.md
# UART interrupt identification unit

This unit holds the interrupt enable register of a 16550-style serial port and turns the condition flags that the rest of the port raises into one interrupt line and an identification byte. The data path, baud generator and FIFOs are not part of it. They appear only as input flags: receive data ready, receive trigger reached, character timeout, transmit holding register empty, a line-error event and a modem-change event. The host reaches the enable register at offset 1 and the identification register at offset 2, and only while the divisor bank select is low. Register reads also have side effects here. They retire the line-status source, the modem-status source and the transmit-empty source.

Line and modem events are kept in sticky flags. A read of the matching status offset clears each flag. The transmit-empty source is tracked by a three-state machine. TX_IDLE means the holding register is not empty. When the register becomes empty the machine moves TX_IDLE -> TX_ARMED, and the interrupt is then pending. A host read of the identification register while it shows code 0x2 moves TX_ARMED -> TX_ACKED. When the register stops being empty, either TX_ARMED -> TX_IDLE or TX_ACKED -> TX_IDLE follows. The machine then waits for the next empty transition. Every state that no other transition covers holds.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset the enable register reads 0, the identification byte is 0x01 and irq is low.
- R2: A write to offset 1 with bank select low stores data bits 3:0 in the enable register (bit 0 receive, bit 1 transmit-empty, bit 2 line status, bit 3 modem status). A read of offset 1 with bank select low returns them with bits 7:4 zero. A write with bank select high leaves the register unchanged.
- R3: Identification bit 0 is 0 exactly when an enabled source is pending, and irq is high exactly then. Bits 3:0 are 0x6 for line status, 0x4 for receive data, 0xC for character timeout, 0x2 for transmit empty, 0x0 for modem status and 0x1 for none. Bits 7:4 are 0.
- R4: When several enabled sources are pending, the code shows the highest of them. The order is line status, then receive data, then character timeout, then transmit empty, then modem status.
- R5: With the FIFO-on input high, the receive source follows the trigger flag and the timeout flag is honoured. With it low, the receive source follows the data-ready flag and the timeout flag is ignored.
- R6: A line-error event sets a sticky source that is visible from the next cycle. A read of offset 5 clears it. An event in the same cycle as that read leaves it set.
- R7: A modem-change event sets a sticky source that is visible from the next cycle. A read of offset 6 clears it. An event in the same cycle as that read leaves it set.
- R8: The transmit-empty source becomes pending one cycle after the empty flag rises. A read of offset 2 with bank select low while code 0x2 is shown clears it, and it stays clear while the flag stays high. It is raised again after the flag falls and rises. A read with bank select high does not clear it.
- R9: A disabled source never sets irq or appears in the code. Enabling a source that is already pending raises irq in the cycle after the write.
- R10: Reads of offset 2 with bank select low return the identification byte. Reads of any offset other than 1 and 2, or with bank select high, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 3 | Register offset |
| reg_rd | input | 1 | Read strobe, one cycle per access |
| reg_wr | input | 1 | Write strobe, one cycle per access |
| reg_wdata | input | 8 | Write data |
| bank_sel | input | 1 | Divisor bank select; offsets 1 and 2 are reached only when low |
| fifo_on | input | 1 | FIFO mode active |
| rx_ready | input | 1 | Receive data ready (level) |
| rx_trig | input | 1 | Receive FIFO trigger level reached (level) |
| rx_tmo | input | 1 | Receive character timeout (level) |
| thr_empty | input | 1 | Transmit holding register empty (level) |
| line_evt | input | 1 | Line error event (pulse) |
| modem_evt | input | 1 | Modem status change event (pulse) |
| reg_rdata | output | 8 | Read data, combinational from offset |
| ier_out | output | 4 | Interrupt enable register |
| iid_out | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
A sticky flag that is left set or cleared by mistake shows in the cycle after the event or read. Either the code stays stuck at 0x6 or 0x0, or the expected code never appears. A transmit-empty machine in the wrong state shows as code 0x2 coming back after an acknowledge, or never returning after a new empty edge, one cycle after the input moves. A wrong enable bit or priority decision shows at once on iid_out and irq, because both are combinational from the registered state and the level inputs.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    typedef enum logic [3:0] {
        IID_MODEM  = 4'h0,
        IID_NONE   = 4'h1,
        IID_THRE   = 4'h2,
        IID_RXDATA = 4'h4,
        IID_LINE   = 4'h6,
        IID_RXTMO  = 4'hC
    } iid_code_t;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_ARMED = 2'd1,
        TX_ACKED = 2'd2
    } tx_state_t;

endpackage

// File: rtl/uart_irq_sticky.sv
module uart_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // set has precedence over a clearing read in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_o <= 1'b0;
        else        flag_o <= set_i | (flag_o & ~clr_i);
    end
endmodule

// File: rtl/uart_irq_thre_fsm.sv
module uart_irq_thre_fsm
    import uart_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty_i,
    input  logic ack_i,
    output logic pend_o
);
    tx_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE:  if (empty_i) state_d = TX_ARMED;
            TX_ARMED: begin
                if (!empty_i)   state_d = TX_IDLE;
                else if (ack_i) state_d = TX_ACKED;
            end
            TX_ACKED: if (!empty_i) state_d = TX_IDLE;
            default:  state_d = TX_IDLE;
        endcase
    end

    always_comb begin
        pend_o = (state_q == TX_ARMED);
    end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
(
    input  logic      src_line,
    input  logic      src_rx,
    input  logic      src_tmo,
    input  logic      src_thre,
    input  logic      src_modem,
    output iid_code_t code_o
);
    always_comb begin
        if (src_line)       code_o = IID_LINE;
        else if (src_rx)    code_o = IID_RXDATA;
        else if (src_tmo)   code_o = IID_RXTMO;
        else if (src_thre)  code_o = IID_THRE;
        else if (src_modem) code_o = IID_MODEM;
        else                code_o = IID_NONE;
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 8,
    parameter int IER_W   = 4,
    parameter int OFS_IER = 1,
    parameter int OFS_IID = 2,
    parameter int OFS_LSR = 5,
    parameter int OFS_MSR = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_rd,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              bank_sel,
    input  logic              fifo_on,
    input  logic              rx_ready,
    input  logic              rx_trig,
    input  logic              rx_tmo,
    input  logic              thr_empty,
    input  logic              line_evt,
    input  logic              modem_evt,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [IER_W-1:0]  ier_out,
    output logic [DATA_W-1:0] iid_out,
    output logic              irq
);
    localparam int NUM_STICKY = 2;
    localparam int STK_LINE   = 0;
    localparam int STK_MODEM  = 1;
    localparam int EN_RX      = 0;
    localparam int EN_THRE    = 1;
    localparam int EN_LINE    = 2;
    localparam int EN_MODEM   = 3;

    logic hit_ier, hit_iid, hit_lsr, hit_msr;
    assign hit_ier = !bank_sel && (reg_addr == ADDR_W'(OFS_IER));
    assign hit_iid = !bank_sel && (reg_addr == ADDR_W'(OFS_IID));
    assign hit_lsr = (reg_addr == ADDR_W'(OFS_LSR));
    assign hit_msr = (reg_addr == ADDR_W'(OFS_MSR));

    // enable register
    logic [IER_W-1:0] ier_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ier_q <= '0;
        else if (reg_wr && hit_ier) ier_q <= reg_wdata[IER_W-1:0];
    end
    logic unused_wdata_hi;
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:IER_W];

    // sticky event sources
    logic [NUM_STICKY-1:0] stk_set, stk_clr, stk_q;
    assign stk_set[STK_LINE]  = line_evt;
    assign stk_clr[STK_LINE]  = reg_rd && hit_lsr;
    assign stk_set[STK_MODEM] = modem_evt;
    assign stk_clr[STK_MODEM] = reg_rd && hit_msr;

    genvar gi;
    generate
        for (gi = 0; gi < NUM_STICKY; gi++) begin : g_sticky
            uart_irq_sticky u_stk (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (stk_set[gi]),
                .clr_i  (stk_clr[gi]),
                .flag_o (stk_q[gi])
            );
        end
    endgenerate

    // transmit-empty tracker
    iid_code_t code;
    logic      thre_pend, thre_ack;
    assign thre_ack = reg_rd && hit_iid && (code == IID_THRE);

    uart_irq_thre_fsm u_thre (
        .clk     (clk),
        .rst_n   (rst_n),
        .empty_i (thr_empty),
        .ack_i   (thre_ack),
        .pend_o  (thre_pend)
    );

    // masked sources and priority
    logic en_line, en_rx, en_tmo, en_thre, en_modem;
    assign en_line  = ier_q[EN_LINE]  && stk_q[STK_LINE];
    assign en_rx    = ier_q[EN_RX]    && (fifo_on ? rx_trig : rx_ready);
    assign en_tmo   = ier_q[EN_RX]    && fifo_on && rx_tmo;
    assign en_thre  = ier_q[EN_THRE]  && thre_pend;
    assign en_modem = ier_q[EN_MODEM] && stk_q[STK_MODEM];

    uart_irq_prio u_prio (
        .src_line  (en_line),
        .src_rx    (en_rx),
        .src_tmo   (en_tmo),
        .src_thre  (en_thre),
        .src_modem (en_modem),
        .code_o    (code)
    );

    assign iid_out = {{(DATA_W-4){1'b0}}, code};
    assign irq     = (code != IID_NONE);
    assign ier_out = ier_q;

    always_comb begin
        if (hit_ier)      reg_rdata = {{(DATA_W-IER_W){1'b0}}, ier_q};
        else if (hit_iid) reg_rdata = iid_out;
        else              reg_rdata = '0;
    end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       reg_rd,
    input logic       reg_wr,
    input logic [7:0] reg_wdata,
    input logic       bank_sel,
    input logic       line_evt,
    input logic [7:0] reg_rdata,
    input logic [3:0] ier_out,
    input logic [7:0] iid_out,
    input logic       irq
);
    logic ier_wr;
    assign ier_wr = reg_wr && !bank_sel && (reg_addr == 3'd1);

    assert_irq_matches_pend_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq == !iid_out[0]);

    assert_ier_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ier_wr |=> ier_out == $past(reg_wdata[3:0]));

    assert_ier_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !ier_wr |=> $stable(ier_out));

    assert_line_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_evt && ier_out[2] && !ier_wr) |=> iid_out[3:0] == 4'h6);

    assert_thre_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !bank_sel && reg_addr == 3'd2 && iid_out[3:0] == 4'h2) |=> iid_out[3:0] != 4'h2);

    assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ier_out == 4'h0) |-> (!irq && iid_out == 8'h01));

    assert_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_sel || (reg_addr != 3'd1 && reg_addr != 3'd2)) |-> reg_rdata == 8'h00);
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_rd    (reg_rd),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .bank_sel  (bank_sel),
    .line_evt  (line_evt),
    .reg_rdata (reg_rdata),
    .ier_out   (ier_out),
    .iid_out   (iid_out),
    .irq       (irq)
);

// File: tb/uart_irq_ident_bench.sv
`timescale 1ns/1ps
module uart_irq_ident_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_rd = 1'b0, reg_wr = 1'b0, bank_sel = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic       fifo_on = 0, rx_ready = 0, rx_trig = 0, rx_tmo = 0;
    logic       thr_empty = 0, line_evt = 0, modem_evt = 0;
    logic [7:0] reg_rdata, iid_out;
    logic [3:0] ier_out;
    logic       irq;

    always #2 clk = ~clk;

    uart_irq_ident u_uart_irq_ident (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rd(reg_rd),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .bank_sel(bank_sel),
        .fifo_on(fifo_on), .rx_ready(rx_ready), .rx_trig(rx_trig),
        .rx_tmo(rx_tmo), .thr_empty(thr_empty), .line_evt(line_evt),
        .modem_evt(modem_evt), .reg_rdata(reg_rdata), .ier_out(ier_out),
        .iid_out(iid_out), .irq(irq)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // {ier[3:0], fifo, rdy, trig, tmo, thr, line, modem, 0, expected code[3:0]}
    localparam int NVEC = 14;
    localparam logic [15:0] VEC [NVEC] = '{
        16'hF4E6, 16'hF4A4, 16'hF3A2, 16'hFDAC, 16'hFF04, 16'hF020, 16'hB060,
        16'h0FE1, 16'h24E2, 16'h80A0, 16'h190C, 16'h4046, 16'hEB20, 16'h1C01
    };

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic reg_write(input logic [2:0] a, input logic [7:0] d, input logic sel);
        reg_addr = a; reg_wdata = d; bank_sel = sel; reg_wr = 1'b1;
        tick();
        reg_wr = 1'b0; bank_sel = 1'b0;
    endtask

    task automatic reg_read(input logic [2:0] a, input logic sel, output logic [7:0] d);
        reg_addr = a; bank_sel = sel; reg_rd = 1'b1;
        #1 d = reg_rdata;
        tick();
        reg_rd = 1'b0; bank_sel = 1'b0;
    endtask

    task automatic quiet();
        logic [7:0] dummy;
        fifo_on = 0; rx_ready = 0; rx_trig = 0; rx_tmo = 0; thr_empty = 0;
        line_evt = 0; modem_evt = 0;
        reg_read(3'd5, 1'b0, dummy);
        reg_read(3'd6, 1'b0, dummy);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        // R1: reset state
        check8("R1 ier", {4'h0, ier_out}, 8'h00);
        check8("R1 iid", iid_out, 8'h01);
        check8("R1 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        tick();
        reg_read(3'd1, 1'b0, rd);
        check8("R1 ier read", rd, 8'h00);

        // R2: write, readback, bank select
        reg_write(3'd1, 8'hFF, 1'b0);
        reg_read(3'd1, 1'b0, rd);
        check8("R2 readback", rd, 8'h0F);
        reg_write(3'd1, 8'h00, 1'b1);
        check8("R2 bank write ignored", {4'h0, ier_out}, 8'h0F);
        reg_read(3'd1, 1'b1, rd);
        check8("R10 bank read zero", rd, 8'h00);
        reg_read(3'd3, 1'b0, rd);
        check8("R10 other offset zero", rd, 8'h00);

        // table walk: R3 R4 R5
        for (int i = 0; i < NVEC; i++) begin
            logic [15:0] v;
            v = VEC[i];
            quiet();
            reg_write(3'd1, {4'h0, v[15:12]}, 1'b0);
            fifo_on = v[11]; rx_ready = v[10]; rx_trig = v[9]; rx_tmo = v[8];
            thr_empty = v[7]; line_evt = v[6]; modem_evt = v[5];
            tick();
            line_evt = 0; modem_evt = 0;
            check8("R4_R5 code", iid_out, {4'h0, v[3:0]});
            check8("R3 irq", {7'd0, irq}, {7'd0, (v[3:0] != 4'h1)});
            reg_read(3'd2, 1'b0, rd);
            check8("R10 iid read", rd, {4'h0, v[3:0]});
        end

        // R6: line sticky
        quiet();
        reg_write(3'd1, 8'h04, 1'b0);
        line_evt = 1; tick(); line_evt = 0;
        check8("R6 set", iid_out, 8'h06);
        tick();
        check8("R6 held", iid_out, 8'h06);
        reg_read(3'd5, 1'b0, rd);
        check8("R6 cleared", iid_out, 8'h01);
        line_evt = 1; reg_read(3'd5, 1'b0, rd); line_evt = 0;
        check8("R6 set wins", iid_out, 8'h06);

        // R7: modem sticky
        quiet();
        reg_write(3'd1, 8'h08, 1'b0);
        modem_evt = 1; tick(); modem_evt = 0;
        check8("R7 set", iid_out, 8'h00);
        check8("R7 irq", {7'd0, irq}, 8'h01);
        reg_read(3'd6, 1'b0, rd);
        check8("R7 cleared", iid_out, 8'h01);
        modem_evt = 1; reg_read(3'd6, 1'b0, rd); modem_evt = 0;
        check8("R7 set wins", iid_out, 8'h00);

        // R8: transmit-empty acknowledge
        quiet();
        reg_write(3'd1, 8'h02, 1'b0);
        thr_empty = 1; tick();
        check8("R8 raised", iid_out, 8'h02);
        reg_read(3'd2, 1'b1, rd);
        check8("R8 bank read no clear", iid_out, 8'h02);
        reg_read(3'd2, 1'b0, rd);
        check8("R8 read value", rd, 8'h02);
        check8("R8 cleared", iid_out, 8'h01);
        tick(); tick(); tick();
        check8("R8 stays clear", iid_out, 8'h01);
        thr_empty = 0; tick();
        thr_empty = 1; tick();
        check8("R8 re-raised", iid_out, 8'h02);

        // R9: enable an already pending source
        quiet();
        reg_write(3'd1, 8'h00, 1'b0);
        rx_ready = 1; tick();
        check8("R9 masked", {7'd0, irq}, 8'h00);
        reg_write(3'd1, 8'h01, 1'b0);
        check8("R9 enabled irq", {7'd0, irq}, 8'h01);
        check8("R9 enabled code", iid_out, 8'h04);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule